// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Interface

This block is the digital front end of a four-channel, 12-bit voltage converter. A host reaches it over a parallel bus: a 12-bit data path, a two-bit channel address, a read/write select and an active-low chip select. Each channel holds a first-stage staging register and a second-stage code register. The core converter takes its codes from the second stage. The staging registers can be read back over the bus.

A shared active-low load strobe moves all four staging values into the code registers at the same time. A host can therefore stage new values on every channel and then update all outputs in one step. It can also keep the strobe low so that each write passes straight through to its channel's output. An active-low asynchronous reset forces every register to mid-scale or zero-scale, as a parameter selects. Any register that is holding when reset is released keeps that value.

The transparent behaviour of level-sensitive latches is modelled with flip-flops on the system clock. While a stage is enabled, it reloads on every clock edge. The block assumes that bus inputs are synchronous to `clk`. The reset asserts asynchronously, and its release passes through a synchroniser.

Top module: `qdac_regif`

## Requirements
- R1: A low level on `arst_n` forces every staging register and every code on `dac_codes` to the reset value at once, without waiting for a clock edge.
- R2: With `cs_n` low and `rw` low, the addressed staging register loads `bus_din` at every clock edge. It keeps the last value loaded once `cs_n` or `rw` goes high.
- R3: The channel is chosen by `addr`: 0 selects channel 0 (bits 11:0 of `dac_codes`), 1 selects channel 1 (bits 23:12), 2 selects channel 2 (bits 35:24) and 3 selects channel 3 (bits 47:36). A write changes only the addressed channel's staging register.
- R4: With `cs_n` low and `rw` high, `bus_dout` shows the addressed staging register, and no staging register changes.
- R5: With `cs_n` high, no staging register changes.
- R6: At a clock edge where `ld_n` is low, all four codes take the values their staging registers hold after that same edge. At an edge where `ld_n` is high, all four codes hold.
- R7: With `ld_n` held low, a write reaches the addressed code at the same clock edge that loads the staging register.
- R8: After `arst_n` is released with the bus idle and `ld_n` high, every staging register and every code keeps the reset value.
- R9: `bus_oe` is 1 only while `cs_n` is low and `rw` is high. At all other times it is 0.
- R10: With `RESET_MID` = 1 the reset value is 0x800. With `RESET_MID` = 0 it is 0x000. Data is plain straight binary, with bit 0 as the least significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read back, 0 = write |
| addr | input | 2 | Channel select |
| ld_n | input | 1 | Load strobe for the code registers, active low |
| bus_din | input | 12 | Write data from the bus |
| bus_dout | output | 12 | Read-back data to the bus |
| bus_oe | output | 1 | Bus drive enable for the read-back path |
| dac_codes | output | 48 | Four 12-bit codes, channel 0 in the lowest bits |

## Verification
The bench builds two copies of the block with the default width of 12 bits and four channels. The first uses `RESET_MID` = 1 and the second uses `RESET_MID` = 0, and both receive the same stimulus. This shows the mid-scale and zero-scale reset values side by side, including the case where reset lands in the middle of a write. The four-channel default makes every address value reachable, so both the simultaneous load of all channels and the pass-through mode are exercised on every channel.

// File: rtl/qdac_pkg.sv
// Package qdac_pkg
// Shared definitions for the quad register interface: bus access kinds and
// the helper that derives the reset code from the variant parameter.
package qdac_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } qdac_acc_e;

    // Reset code: mid-scale (top bit only) or all zeros.
    function automatic logic [31:0] qdac_reset_code(input int width, input bit mid);
        logic [31:0] v;
        v = '0;
        if (mid) v[width-1] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/qdac_rst_sync.sv
// Module qdac_rst_sync
// Reset conditioner. Assertion passes straight through (asynchronous); release
// is delayed through STAGES flops on clk. Assumes arst_n may change at any time.
module qdac_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear the chain at once on assertion.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/qdac_decode.sv
// Module qdac_decode
// Bus decoder and read-back selector. Turns chip select, direction and address
// into one write enable per channel and a read enable, and picks the addressed
// staging value for the read path. Assumes bus inputs are synchronous to clk.
module qdac_decode
    import qdac_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 12,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     rw,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_CH*DATA_W-1:0] stage_flat,
    output logic [NUM_CH-1:0]        wr_en,
    output logic                     rd_en,
    output logic [DATA_W-1:0]        rd_data
);
    qdac_acc_e acc;

    // Classify the current bus access.
    always_comb begin
        if (cs_n)    acc = ACC_IDLE;
        else if (rw) acc = ACC_READ;
        else         acc = ACC_WRITE;
    end

    assign rd_en = (acc == ACC_READ);

    // One write enable per channel, raised only for the addressed one.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_wen
        assign wr_en[c] = (acc == ACC_WRITE) && (addr == ADDR_W'(c));
    end

    // Read-back selector over the staging registers.
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(c)) rd_data = stage_flat[c*DATA_W +: DATA_W];
        end
    end

    // R3: never more than one staging register open at a time.
    a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R4: a read cycle opens no staging register.
    a_r4_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (wr_en == '0));

endmodule

// File: rtl/qdac_chan.sv
// Module qdac_chan
// One converter channel: staging register plus code register. The staging
// register reloads from the bus every edge its write enable is high; the code
// register reloads from the staging register's next value while ld_n is low,
// so a pass-through write lands in both on the same edge.
module qdac_chan #(
    parameter int          DATA_W  = 12,
    parameter logic [31:0] RST_VAL = 32'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              ld_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] stage_q,
    output logic [DATA_W-1:0] code_q
);
    localparam logic [DATA_W-1:0] RV = RST_VAL[DATA_W-1:0];

    logic [DATA_W-1:0] stage_d;

    // Next staging value: bus while open, otherwise hold.
    assign stage_d = wr_en ? din : stage_q;

    // Staging register with asynchronous reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= RV;
        else        stage_q <= stage_d;
    end

    // Code register, loaded while the load strobe is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     code_q <= RV;
        else if (!ld_n) code_q <= stage_d;
    end

    // R2: an open staging register captures the bus value.
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (stage_q == $past(din)));

    // R5: a closed staging register holds.
    a_r5_hold_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(stage_q));

    // R6: a high load strobe freezes the code.
    a_r6_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> $stable(code_q));

    // R6: a low load strobe makes the code match the staging register.
    a_r6_code_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> (code_q == stage_q));

    // R8: both stages come out of reset at the reset value.
    a_r8_release_value: assert property (@(posedge clk)
        $rose(rst_n) |-> (stage_q == RV && code_q == RV));

endmodule

// File: rtl/qdac_regif.sv
// Module qdac_regif
// Top of the quad double-buffered register interface. Conditions the reset,
// decodes bus accesses, instantiates one channel per converter and presents
// the read-back bus and the four codes. Assumes bus inputs synchronous to clk.
module qdac_regif
    import qdac_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DATA_W    = 12,
    parameter bit RESET_MID = 1'b1,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam logic [31:0] RST_CODE = qdac_reset_code(DATA_W, RESET_MID)
) (
    input  logic                     clk,
    input  logic                     arst_n,
    input  logic                     cs_n,
    input  logic                     rw,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     ld_n,
    input  logic [DATA_W-1:0]        bus_din,
    output logic [DATA_W-1:0]        bus_dout,
    output logic                     bus_oe,
    output logic [NUM_CH*DATA_W-1:0] dac_codes
);
    logic                     rst_n;
    logic [NUM_CH-1:0]        wr_en;
    logic                     rd_en;
    logic [DATA_W-1:0]        rd_data;
    logic [NUM_CH*DATA_W-1:0] stage_flat;

    qdac_rst_sync #(.STAGES(2)) u_rst (
        .clk    (clk),
        .arst_n (arst_n),
        .rst_n  (rst_n)
    );

    qdac_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rw         (rw),
        .addr       (addr),
        .stage_flat (stage_flat),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .rd_data    (rd_data)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        qdac_chan #(.DATA_W(DATA_W), .RST_VAL(RST_CODE)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[c]),
            .ld_n    (ld_n),
            .din     (bus_din),
            .stage_q (stage_flat[c*DATA_W +: DATA_W]),
            .code_q  (dac_codes[c*DATA_W +: DATA_W])
        );
    end

    // Read-back drive: data only while a read is in progress.
    assign bus_oe   = rd_en;
    assign bus_dout = rd_en ? rd_data : '0;

    // R9: the bus is never driven outside a read access.
    a_r9_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !rw) |-> (!bus_oe && bus_dout == '0));

endmodule

// File: tb/tb_qdac_regif.sv
module tb_qdac_regif;
    localparam int NCH = 4;
    localparam int DW  = 12;
    localparam logic [DW-1:0] RMID  = 12'h800;
    localparam logic [DW-1:0] RZERO = 12'h000;

    logic clk = 1'b0;
    logic arst_n, cs_n, rw, ld_n;
    logic [1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout, dout_z;
    logic oe, oe_z;
    logic [NCH*DW-1:0] codes, codes_z;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [DW-1:0] stg_m [NCH];
    logic [DW-1:0] out_m [NCH];

    always #4 clk = ~clk;

    qdac_regif #(.NUM_CH(NCH), .DATA_W(DW), .RESET_MID(1'b1)) dut (
        .clk(clk), .arst_n(arst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
        .ld_n(ld_n), .bus_din(din), .bus_dout(dout), .bus_oe(oe),
        .dac_codes(codes));

    qdac_regif #(.NUM_CH(NCH), .DATA_W(DW), .RESET_MID(1'b0)) dut_z (
        .clk(clk), .arst_n(arst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
        .ld_n(ld_n), .bus_din(din), .bus_dout(dout_z), .bus_oe(oe_z),
        .dac_codes(codes_z));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] code_of(input logic [NCH*DW-1:0] v, input int c);
        return v[c*DW +: DW];
    endfunction

    // Model of one clock edge, derived from R2..R7.
    task automatic model_edge();
        logic [DW-1:0] nxt [NCH];
        for (int c = 0; c < NCH; c++) nxt[c] = stg_m[c];
        if (!cs_n && !rw) nxt[addr] = din;
        for (int c = 0; c < NCH; c++) begin
            stg_m[c] = nxt[c];
            if (!ld_n) out_m[c] = nxt[c];
        end
    endtask

    task automatic model_reset(input logic [DW-1:0] v);
        for (int c = 0; c < NCH; c++) begin
            stg_m[c] = v;
            out_m[c] = v;
        end
    endtask

    task automatic check_codes(input string req);
        for (int c = 0; c < NCH; c++) chk(req, code_of(codes, c), out_m[c]);
    endtask

    // One bus cycle: check state from the previous edge, drive, check the
    // combinational bus, take the edge and advance the model.
    task automatic bus_cycle(input logic c_n, input logic r, input logic [1:0] a,
                             input logic [DW-1:0] d, input logic l_n, input string req);
        @(negedge clk);
        check_codes(req);
        cs_n = c_n; rw = r; addr = a; din = d; ld_n = l_n;
        #1;
        if (!c_n && r) begin
            chk("R4 readback", dout, stg_m[a]);
            chk("R9 oe in read", {11'd0, oe}, 12'd1);
        end else begin
            chk("R9 oe quiet", {11'd0, oe}, 12'd0);
        end
        @(posedge clk);
        model_edge();
    endtask

    task automatic readback_all(input string req);
        for (int c = 0; c < NCH; c++) bus_cycle(1'b0, 1'b1, 2'(c), 12'h000, 1'b1, req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        arst_n = 1'b0; cs_n = 1'b1; rw = 1'b0; addr = '0; din = '0; ld_n = 1'b1;
        model_reset(RMID);
        repeat (4) @(posedge clk);
        @(negedge clk) arst_n = 1'b1;
        repeat (4) bus_cycle(1'b1, 1'b0, 2'd0, 12'h000, 1'b1, "R8 idle after release");

        // R1/R10 reset state of both variants
        for (int c = 0; c < NCH; c++) begin
            chk("R10 mid reset code", code_of(codes, c), RMID);
            chk("R10 zero reset code", code_of(codes_z, c), RZERO);
        end
        readback_all("R8 readback after reset");

        // R2/R3 write each channel with ld_n high: codes hold (R6)
        bus_cycle(1'b0, 1'b0, 2'd0, 12'h111, 1'b1, "R3 write ch0");
        bus_cycle(1'b0, 1'b0, 2'd1, 12'h222, 1'b1, "R3 write ch1");
        bus_cycle(1'b0, 1'b0, 2'd2, 12'h333, 1'b1, "R3 write ch2");
        bus_cycle(1'b0, 1'b0, 2'd3, 12'hFFF, 1'b1, "R3 write ch3");
        // R4 readback while codes still hold old values
        readback_all("R6 codes hold during readback");
        for (int c = 0; c < NCH; c++) chk("R6 codes unchanged before load", code_of(codes, c), RMID);

        // R2 transparency: several values while open, last one kept
        bus_cycle(1'b0, 1'b0, 2'd1, 12'h0A5, 1'b1, "R2 open");
        bus_cycle(1'b0, 1'b0, 2'd1, 12'h5A0, 1'b1, "R2 open");
        bus_cycle(1'b1, 1'b0, 2'd1, 12'h777, 1'b1, "R5 closed");
        bus_cycle(1'b0, 1'b1, 2'd1, 12'h777, 1'b1, "R2 last value kept");

        // R6 simultaneous update of all four
        bus_cycle(1'b1, 1'b0, 2'd0, 12'h000, 1'b0, "R6 load all");
        bus_cycle(1'b1, 1'b0, 2'd0, 12'h000, 1'b1, "R6 load all");
        chk("R6 simultaneous ch0", code_of(codes, 0), 12'h111);
        chk("R6 simultaneous ch1", code_of(codes, 1), 12'h5A0);
        chk("R6 simultaneous ch2", code_of(codes, 2), 12'h333);
        chk("R6 simultaneous ch3", code_of(codes, 3), 12'hFFF);

        // R7 pass-through with ld_n held low
        bus_cycle(1'b0, 1'b0, 2'd2, 12'h9C3, 1'b0, "R7 pass-through");
        @(negedge clk);
        chk("R7 same-edge update", code_of(codes, 2), 12'h9C3);
        bus_cycle(1'b0, 1'b0, 2'd3, 12'h001, 1'b0, "R7 pass-through");
        bus_cycle(1'b1, 1'b0, 2'd0, 12'h000, 1'b1, "R7 pass-through");

        // Constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic c_n, r, l_n;
            c_n = ($urandom % 4) == 0;
            r   = ($urandom % 3) == 0;
            l_n = ($urandom % 4) != 0;
            bus_cycle(c_n, r, 2'($urandom % 4), 12'($urandom), l_n, "R2/R6 random");
        end

        // R1 reset in the middle of a write
        @(negedge clk);
        check_codes("R6 before reset");
        cs_n = 1'b0; rw = 1'b0; addr = 2'd2; din = 12'h4B4; ld_n = 1'b0;
        #1 arst_n = 1'b0;
        #1;
        model_reset(RMID);
        for (int c = 0; c < NCH; c++) begin
            chk("R1 immediate mid reset", code_of(codes, c), RMID);
            chk("R1 immediate zero reset", code_of(codes_z, c), RZERO);
        end
        cs_n = 1'b1; ld_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) arst_n = 1'b1;
        repeat (4) bus_cycle(1'b1, 1'b0, 2'd0, 12'h000, 1'b1, "R8 hold after release");
        readback_all("R8 readback keeps reset");
        for (int c = 0; c < NCH; c++) chk("R10 zero variant after release", code_of(codes_z, c), RZERO);

        @(negedge clk);
        check_codes("R8 final");
        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule